// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory DMA Controller

This block copies one word from a peripheral register into memory with no processor code in the path. The processor first programs a source and a destination address. A peripheral then raises a request. The controller asks the processor for the system bus, and once the processor grants it, the controller reads the source word, writes it to the destination and hands the bus back.

Two four-phase handshakes nest around every transfer. The outer one runs with the processor (bus request and bus grant). The inner one runs with the peripheral (request and acknowledge). The controller drops its bus request and its acknowledge together. It does not go back to idle until both the grant and the peripheral request have fallen. A done flag records each completed transfer and is cleared by a processor write.

Top module: `dma_handshake`

## Requirements
- R1: After reset, bus_req, per_ack, m_rd and m_wr are 0, m_addr and m_wdata are 0, and xfer_done is 0. The source address resets to 0x8000 and the destination address resets to 0x0001.
- R2: When per_req is high while the controller is idle, bus_req is high from the next cycle on.
- R3: While bus_req is high and bus_gnt is low, per_ack stays 0 and no bus strobe is driven.
- R4: In the first cycle after the grant is seen, per_ack is 1, m_rd is 1 and m_addr equals the source address.
- R5: In the following cycle, m_wr is 1, m_addr equals the destination address and m_wdata equals the word read in the previous cycle.
- R6: After the write cycle, bus_req and per_ack fall on the same clock edge.
- R7: After release, bus_req stays 0 while per_req or bus_gnt is still high. A new transfer starts only after both have been low.
- R8: xfer_done is set by each completed write. A write with cfg_sel=2 clears it. If the clear and a completing write fall on the same edge, the set wins.
- R9: A write with cfg_sel=0 loads the source address and a write with cfg_sel=1 loads the destination address from cfg_wdata. Later transfers use the loaded values.
- R10: When bus_gnt is low, m_rd, m_wr, m_addr and m_wdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 = source, 1 = destination, 2 = clear done |
| cfg_wdata | input | AW | Configuration write data |
| xfer_done | output | 1 | Transfer-complete flag |
| per_req | input | 1 | Peripheral request |
| per_ack | output | 1 | Acknowledge to the peripheral |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| m_addr | output | AW | Bus address |
| m_rd | output | 1 | Bus read strobe |
| m_wr | output | 1 | Bus write strobe |
| m_wdata | output | DW | Bus write data |
| m_rdata | input | DW | Bus read data (sampled in the read cycle) |

## Verification
The runs cover several grant delays:
- An immediate grant shows that the read comes straight after the grant.
- A grant delayed by several cycles shows that nothing reaches the bus or the peripheral before the grant.

The release runs check the two stale conditions separately:
- The peripheral holds its request long after release.
- The processor holds the grant after release.

Each must fail to start a second transfer.

The read data depends on the address, so a wrong source address or a stale holding register shows up as a data mismatch at the write. The clear of the done flag is also driven in the same cycle as a completing write, to show that the set wins.

// File: rtl/dma_handshake.sv
module dma_handshake #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] SRC_RST = AW'('h8000),
  parameter logic [AW-1:0] DST_RST = AW'('h0001)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          xfer_done,
  input  logic          per_req,
  output logic          per_ack,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] m_addr,
  output logic          m_rd,
  output logic          m_wr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ASK, S_RD, S_WR, S_REL} st_t;

  st_t st, st_nx;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] hold_q;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (per_req) st_nx = S_ASK;
      S_ASK:   if (bus_gnt) st_nx = S_RD;
      S_RD:    if (bus_gnt) st_nx = S_WR;
      S_WR:    if (bus_gnt) st_nx = S_REL;
      S_REL:   if (!bus_gnt && !per_req) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  assign bus_req = (st == S_ASK) || (st == S_RD) || (st == S_WR);
  assign per_ack = (st == S_RD) || (st == S_WR);
  assign m_rd    = bus_gnt && (st == S_RD);
  assign m_wr    = bus_gnt && (st == S_WR);
  assign m_addr  = m_rd ? src_q : (m_wr ? dst_q : '0);
  assign m_wdata = m_wr ? hold_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      src_q     <= SRC_RST;
      dst_q     <= DST_RST;
      hold_q    <= '0;
      xfer_done <= 1'b0;
    end else begin
      st <= st_nx;
      if (m_rd) hold_q <= m_rdata;
      if (cfg_wr && cfg_sel == 2'd0) src_q <= cfg_wdata;
      if (cfg_wr && cfg_sel == 2'd1) dst_q <= cfg_wdata;
      if (m_wr) xfer_done <= 1'b1;
      else if (cfg_wr && cfg_sel == 2'd2) xfer_done <= 1'b0;
    end
  end

  a_r2_req_asks_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && per_req) |=> bus_req);
  a_r3_ack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_ack) |-> $past(bus_gnt));
  a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd |=> (m_wr || !bus_gnt));
  a_r6_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_ack) |-> $fell(bus_req));
  a_r7_no_retake: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REL && (per_req || bus_gnt)) |=> !bus_req);
  a_r8_done_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr |=> xfer_done);

endmodule

// File: tb/dma_handshake_tb.sv
`timescale 1ns/1ps
module dma_handshake_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [DW-1:0] KEY = 16'hA5C3;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [1:0] cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic xfer_done, per_req = 0, per_ack, bus_req, bus_gnt = 0;
  logic [AW-1:0] m_addr;
  logic m_rd, m_wr;
  logic [DW-1:0] m_wdata, m_rdata;

  int checks = 0, errors = 0;
  int glat = 0, rlat = 0;
  logic [47:0] exp_q[$];

  always #2 clk = ~clk;
  assign m_rdata = m_addr ^ KEY;

  dma_handshake #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .xfer_done(xfer_done), .per_req(per_req), .per_ack(per_ack), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr), .m_wdata(m_wdata),
    .m_rdata(m_rdata));

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // processor model: grants after glat cycles, holds grant rlat cycles after release
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (bus_req && !bus_gnt) begin
        if (cnt >= glat) begin bus_gnt = 1; cnt = 0; end else cnt++;
      end else if (!bus_req && bus_gnt) begin
        if (cnt >= rlat) begin bus_gnt = 0; cnt = 0; end else cnt++;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    logic pa, pb;
    logic [47:0] e;
    pa = 0; pb = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!bus_gnt) begin
          chk(!m_rd && !m_wr && m_addr == 0 && m_wdata == 0, "R10", {m_rd, m_wr, m_addr, m_wdata}, 0);
          chk(!per_ack, "R3", per_ack, 0);
        end
        if (m_rd) begin
          e = (exp_q.size() > 0) ? exp_q[0] : 48'hx;
          chk(m_addr == e[47:32] && per_ack, "R4", {per_ack, m_addr}, {1'b1, e[47:32]});
        end
        if (m_wr) begin
          if (exp_q.size() == 0) chk(0, "R5", m_addr, 0);
          else begin
            e = exp_q.pop_front();
            chk({m_addr, m_wdata} == e[31:0], "R5", {m_addr, m_wdata}, e[31:0]);
          end
        end
        if (pa && !per_ack) chk(pb && !bus_req, "R6", {pb, bus_req}, 2'b10);
      end
      pa = per_ack; pb = bus_req;
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] v);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic xfer(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                      input int gl, input int rl, input int hold, input bit clr);
    glat = gl; rlat = rl;
    exp_q.push_back({src, dst, src ^ KEY});
    @(negedge clk); per_req = 1;
    @(negedge clk);
    chk(bus_req, "R2", bus_req, 1);
    while (!m_wr) @(negedge clk);
    if (clr) begin cfg_wr = 1; cfg_sel = 2; end
    @(negedge clk);
    cfg_wr = 0;
    chk(xfer_done, "R8", xfer_done, 1);
    repeat (hold) begin
      chk(!bus_req, "R7", bus_req, 0);
      @(negedge clk);
    end
    per_req = 0;
    while (bus_gnt) begin
      chk(!bus_req, "R7", bus_req, 0);
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk(!bus_req, "R7", bus_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_req && !per_ack && !m_rd && !m_wr && m_addr == 0 && m_wdata == 0 && !xfer_done,
        "R1", {bus_req, per_ack, m_rd, m_wr, xfer_done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && !xfer_done, "R1", {bus_req, xfer_done}, 0);
    // R1 defaults: source 0x8000, destination 0x0001
    xfer(16'h8000, 16'h0001, 0, 0, 0, 0);
    cfg(2, 0);
    @(negedge clk);
    chk(!xfer_done, "R8", xfer_done, 0);
    // R9 reprogram, delayed grant, peripheral holds request (R7)
    cfg(0, 16'h1234);
    cfg(1, 16'h0F00);
    xfer(16'h1234, 16'h0F00, 3, 0, 5, 0);
    // processor holds grant after release (R7)
    cfg(0, 16'h00FF);
    xfer(16'h00FF, 16'h0F00, 1, 4, 0, 0);
    // clear in the same cycle as the completing write: set wins (R8)
    cfg(2, 0);
    cfg(1, 16'h7777);
    xfer(16'h00FF, 16'h7777, 2, 1, 2, 1);
    chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule